// File: doc/BRIEF.md
# Cascaded Compare Timer with Toggle Output

This block is a small free-running timer split into a 4-bit low stage and an 8-bit high stage. Each stage has its own compare register. With the join select high, the two stages form one 12-bit counter, and both compare registers together form one 12-bit compare value. With the join select low, the low stage works as a programmable prescaler: it counts up to its compare value, wraps, and advances the high stage once per wrap. The high stage then compares against its own register.

The counter event, called here the match, can do three things: toggle an output flip-flop, clear the counter, and raise a one-cycle interrupt pulse. The overflow of the counter (12-bit or high stage) can also toggle the output and raise the interrupt. A 4-bit mode register holds the mask bits that gate these actions. A separate flag selects the alternate output mode. In that mode, the compare-toggle bit steers the interrupt to the match.

Software writes the registers through one shared data bus with three write strobes. The counters advance on every clock outside reset.

Top module: `cascade_cmp_timer`

## Requirements
- R1: Synchronous reset clears both counters, the toggle output and the interrupt output, and loads the mode register with 0000, the low compare with 1111 and the high compare with 11111111; with no further writes in split mode the high stage therefore advances once every 16 cycles.
- R2: With the join select high, {high,low} counts up by one each cycle, a match is {high,low} equal to {high compare, low compare}, and the count wraps from 0xFFF to 0 as an overflow.
- R3: With the join select low and a nonzero low compare, the low stage counts up each cycle; in the cycle where it equals the low compare it returns to 0 and the high stage advances, otherwise the high stage holds. A high-stage match is an advance while high equals the high compare, and an overflow is an advance while high is 0xFF.
- R4: With the join select low and a low compare of 0, the low stage stays at 0 and the high stage advances every cycle.
- R5: Mode bit 1 set: a match clears the counter (both stages in joined mode, the high stage in split mode) at the next edge instead of incrementing it.
- R6: Mode bit 2 set: a match inverts the toggle output at the next edge.
- R7: Mode bit 3 set: an overflow inverts the toggle output at the next edge; a match and an overflow in the same cycle invert it only once.
- R8: The interrupt source is the match when mode bit 3 is 0, or when the alternate-mode flag is 1 and mode bit 2 is 1; in every other case it is the overflow.
- R9: The interrupt output is high for exactly the one cycle after each event from the selected source, and only while mode bit 0 is 1.
- R10: A match in a cycle in which a compare register is written (either one in joined mode, the high one in split mode) is discarded: no toggle, no clear, no interrupt; the counter increments as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state on rising edge |
| rst | input | 1 | Synchronous reset, active high |
| join12 | input | 1 | 1: one 12-bit counter; 0: prescaler plus 8-bit stage |
| out_mode7 | input | 1 | Alternate output mode flag for interrupt source selection |
| wr_mode | input | 1 | Write strobe for the mode register (wdata[3:0]) |
| wr_cmp_lo | input | 1 | Write strobe for the low compare register (wdata[3:0]) |
| wr_cmp_hi | input | 1 | Write strobe for the high compare register (wdata[7:0]) |
| wdata | input | 8 | Shared register write data |
| tog_out | output | 1 | Toggle flip-flop |
| irq_out | output | 1 | One-cycle interrupt pulse |
| cnt_lo | output | 4 | Low stage count |
| cnt_hi | output | 8 | High stage count |

## Verification
The assertions check the per-cycle rules on every clock. These rules are the 12-bit wrap, the held low stage and the moving high stage under bypass, the high stage holding between prescaler wraps, the clear after an unsuppressed joined match, the gating of interrupts by the enable bit, and the quiet toggle and interrupt in a cycle with a compare write. Some effects show only over a whole run, so the bench scenarios cover them. These are the periods that result from each compare setting, the count of toggles with overflow and match together, the choice of interrupt source across the flag combinations, and the reset values of the compare registers seen as a 16-cycle prescale.

// File: rtl/cascade_cmp_timer.sv
module cascade_cmp_timer #(
  parameter int LO_W = 4,
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            join12,
  input  logic            out_mode7,
  input  logic            wr_mode,
  input  logic            wr_cmp_lo,
  input  logic            wr_cmp_hi,
  input  logic [HI_W-1:0] wdata,
  output logic            tog_out,
  output logic            irq_out,
  output logic [LO_W-1:0] cnt_lo,
  output logic [HI_W-1:0] cnt_hi
);
  localparam int FULL_W = LO_W + HI_W;

  logic [3:0]      mode_q;
  logic [LO_W-1:0] cmp_lo_q;
  logic [HI_W-1:0] cmp_hi_q;

  wire en_irq  = mode_q[0];
  wire en_clr  = mode_q[1];
  wire en_ctog = mode_q[2];
  wire en_otog = mode_q[3];

  wire [FULL_W-1:0] cnt_full = {cnt_hi, cnt_lo};
  wire [FULL_W-1:0] cmp_full = {cmp_hi_q, cmp_lo_q};
  wire [FULL_W-1:0] cnt_inc  = cnt_full + 1'b1;

  wire bypass  = ~join12 & (cmp_lo_q == '0);
  wire pre_hit = cnt_lo == cmp_lo_q;
  wire hi_step = bypass | pre_hit;

  wire hit_j = (cnt_full == cmp_full) & ~(wr_cmp_lo | wr_cmp_hi);
  wire hit_s = hi_step & (cnt_hi == cmp_hi_q) & ~wr_cmp_hi;
  wire match = join12 ? hit_j : hit_s;
  wire ovf   = join12 ? (&cnt_full) : (hi_step & (&cnt_hi));
  wire clr   = en_clr & match;

  wire src_match = ~en_otog | (out_mode7 & en_ctog);
  wire flip      = (en_otog & ovf) | (en_ctog & match);
  wire fire      = en_irq & (src_match ? match : ovf);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      cmp_lo_q <= '1;
      cmp_hi_q <= '1;
    end else begin
      if (wr_mode)   mode_q   <= wdata[3:0];
      if (wr_cmp_lo) cmp_lo_q <= wdata[LO_W-1:0];
      if (wr_cmp_hi) cmp_hi_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (join12) begin
      {cnt_hi, cnt_lo} <= clr ? '0 : cnt_inc;
    end else begin
      cnt_lo <= hi_step ? '0 : cnt_lo + 1'b1;
      if (hi_step) cnt_hi <= clr ? '0 : cnt_hi + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_out <= 1'b0;
      irq_out <= 1'b0;
    end else begin
      tog_out <= tog_out ^ flip;
      irq_out <= fire;
    end
  end
endmodule

// File: rtl/cascade_cmp_timer_chk.sv
module cascade_cmp_timer_chk #(
  parameter int LO_W = 4,
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            join12,
  input logic            wr_cmp_lo,
  input logic            wr_cmp_hi,
  input logic            tog_out,
  input logic            irq_out,
  input logic [LO_W-1:0] cnt_lo,
  input logic [HI_W-1:0] cnt_hi,
  input logic [3:0]      mode_q,
  input logic [LO_W-1:0] cmp_lo_q,
  input logic [HI_W-1:0] cmp_hi_q
);
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    join12 && (&cnt_lo) && (&cnt_hi) |=> cnt_lo == '0 && cnt_hi == '0);

  p_prescale_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !join12 && cmp_lo_q != '0 && cnt_lo != cmp_lo_q |=> $stable(cnt_hi));

  p_bypass_r4: assert property (@(posedge clk) disable iff (rst)
    !join12 && cmp_lo_q == '0 && cmp_hi_q != '0 |=> cnt_lo == '0 && cnt_hi != $past(cnt_hi));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    join12 && mode_q[1] && !wr_cmp_lo && !wr_cmp_hi &&
    {cnt_hi, cnt_lo} == {cmp_hi_q, cmp_lo_q} |=> cnt_lo == '0 && cnt_hi == '0);

  p_irq_enable_r9: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(mode_q[0]));

  p_suppress_r10: assert property (@(posedge clk) disable iff (rst)
    join12 && (wr_cmp_lo || wr_cmp_hi) && !mode_q[3] |=> $stable(tog_out) && !irq_out);
endmodule

bind cascade_cmp_timer cascade_cmp_timer_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst(rst), .join12(join12), .wr_cmp_lo(wr_cmp_lo), .wr_cmp_hi(wr_cmp_hi),
  .tog_out(tog_out), .irq_out(irq_out), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .mode_q(mode_q), .cmp_lo_q(cmp_lo_q), .cmp_hi_q(cmp_hi_q)
);

// File: tb/tb_cascade_cmp_timer.sv
`timescale 1ns/1ps
module tb_cascade_cmp_timer;
  logic clk = 1'b0, rst = 1'b1, join12 = 1'b0, out_mode7 = 1'b0;
  logic wr_mode = 1'b0, wr_cmp_lo = 1'b0, wr_cmp_hi = 1'b0;
  logic [7:0] wdata = '0;
  logic tog_out, irq_out;
  logic [3:0] cnt_lo;
  logic [7:0] cnt_hi;

  cascade_cmp_timer dut (
    .clk(clk), .rst(rst), .join12(join12), .out_mode7(out_mode7),
    .wr_mode(wr_mode), .wr_cmp_lo(wr_cmp_lo), .wr_cmp_hi(wr_cmp_hi), .wdata(wdata),
    .tog_out(tog_out), .irq_out(irq_out), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [3:0] m_mode;
  int m_clo, m_chi, m_lo, m_hi;
  bit m_tog, m_irq;

  typedef struct packed {
    logic       j;
    logic       m7;
    logic [3:0] mode;
    logic [3:0] clo;
    logic [7:0] chi;
    logic [15:0] n;
    logic [3:0] tag;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b1, 1'b0, 4'b0111, 4'h5, 8'h00, 16'd40,   4'd5},
    '{1'b1, 1'b0, 4'b1001, 4'h0, 8'h01, 16'd4200, 4'd2},
    '{1'b1, 1'b1, 4'b1101, 4'h3, 8'h02, 16'd4200, 4'd8},
    '{1'b1, 1'b0, 4'b1101, 4'h3, 8'h02, 16'd4200, 4'd8},
    '{1'b1, 1'b0, 4'b1100, 4'hF, 8'hFF, 16'd4200, 4'd7},
    '{1'b0, 1'b0, 4'b0111, 4'h3, 8'h04, 16'd100,  4'd3},
    '{1'b0, 1'b0, 4'b0111, 4'h0, 8'h09, 16'd60,   4'd4},
    '{1'b0, 1'b0, 4'b1001, 4'h0, 8'h00, 16'd600,  4'd3},
    '{1'b1, 1'b0, 4'b0110, 4'h5, 8'h00, 16'd40,   4'd9},
    '{1'b1, 1'b0, 4'b0001, 4'h5, 8'h00, 16'd40,   4'd6},
    '{1'b0, 1'b1, 4'b0101, 4'h2, 8'h03, 16'd80,   4'd8}
  };

  function automatic string tagname(input int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int c, cc, nlo, nhi;
    bit m, o, step, clr;
    if (rst) begin
      m_mode = '0; m_clo = 15; m_chi = 255; m_lo = 0; m_hi = 0; m_tog = 0; m_irq = 0;
      return;
    end
    if (join12) begin
      c  = m_hi * 16 + m_lo;
      cc = m_chi * 16 + m_clo;
      m  = (c == cc) && !(wr_cmp_lo || wr_cmp_hi);
      o  = (c == 4095);
      clr = m && m_mode[1];
      c  = clr ? 0 : (c + 1) % 4096;
      nlo = c % 16;
      nhi = c / 16;
    end else begin
      step = (m_clo == 0) || (m_lo == m_clo);
      m    = step && (m_hi == m_chi) && !wr_cmp_hi;
      o    = step && (m_hi == 255);
      clr  = m && m_mode[1];
      nlo  = step ? 0 : (m_lo + 1) % 16;
      nhi  = step ? (clr ? 0 : (m_hi + 1) % 256) : m_hi;
    end
    if ((m_mode[3] && o) || (m_mode[2] && m)) m_tog = !m_tog;
    m_irq = m_mode[0] && ((!m_mode[3] || (out_mode7 && m_mode[2])) ? m : o);
    m_lo = nlo;
    m_hi = nhi;
    if (wr_mode)   m_mode = wdata[3:0];
    if (wr_cmp_lo) m_clo  = int'(wdata[3:0]);
    if (wr_cmp_hi) m_chi  = int'(wdata);
  endtask

  task automatic cyc(input string tag);
    int act, exp;
    model_step();
    @(posedge clk);
    @(negedge clk);
    act = {19'd0, tog_out, irq_out, cnt_hi, cnt_lo};
    exp = {19'd0, m_tog, m_irq, m_hi[7:0], m_lo[3:0]};
    check(tag, act == exp, "{tog,irq,hi,lo}", act, exp);
  endtask

  task automatic do_reset(input bit j, input bit m7);
    join12 = j; out_mode7 = m7; rst = 1'b1;
    cyc("R1"); cyc("R1");
    rst = 1'b0;
  endtask

  task automatic wr(input int which, input logic [7:0] d, input string tag);
    wdata = d;
    wr_mode = (which == 0); wr_cmp_lo = (which == 1); wr_cmp_hi = (which == 2);
    cyc(tag);
    wr_mode = 1'b0; wr_cmp_lo = 1'b0; wr_cmp_hi = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    foreach (VECS[i]) begin
      string t;
      t = tagname(int'(VECS[i].tag));
      do_reset(VECS[i].j, VECS[i].m7);
      wr(0, {4'h0, VECS[i].mode}, t);
      wr(1, {4'h0, VECS[i].clo}, t);
      wr(2, VECS[i].chi, t);
      for (int k = 0; k < int'(VECS[i].n); k++) cyc(t);
    end

    // R1: reset state seen at the ports
    do_reset(1'b1, 1'b0);
    rst = 1'b1; cyc("R1");
    check("R1", tog_out == 1'b0, "tog after reset", tog_out, 0);
    check("R1", irq_out == 1'b0, "irq after reset", irq_out, 0);
    check("R1", cnt_lo == 4'd0 && cnt_hi == 8'd0, "count after reset", {cnt_hi, cnt_lo}, 0);
    rst = 1'b0;

    // R1: low compare resets to 1111, so split mode prescales by 16
    do_reset(1'b0, 1'b0);
    for (int k = 0; k < 33; k++) cyc("R1");
    check("R1", cnt_hi == 8'd2, "high stage after 33 cycles", cnt_hi, 2);
    check("R1", cnt_lo == 4'd1, "low stage after 33 cycles", cnt_lo, 1);

    // R10: write to a compare register in the matching cycle
    do_reset(1'b1, 1'b0);
    wr(0, 8'h07, "R10");
    wr(1, 8'h05, "R10");
    wr(2, 8'h00, "R10");
    cyc("R10"); cyc("R10");
    check("R10", cnt_lo == 4'd5, "count before suppressed match", cnt_lo, 5);
    wr(1, 8'h05, "R10");
    check("R10", cnt_lo == 4'd6 && cnt_hi == 8'd0, "count after suppressed match", {cnt_hi, cnt_lo}, 6);
    check("R10", tog_out == 1'b0, "tog after suppressed match", tog_out, 0);
    check("R10", irq_out == 1'b0, "irq after suppressed match", irq_out, 0);

    // R6 / R9: an ordinary match in the same setup toggles and interrupts
    do_reset(1'b1, 1'b0);
    wr(0, 8'h07, "R6");
    wr(1, 8'h05, "R6");
    wr(2, 8'h00, "R6");
    cyc("R6"); cyc("R6"); cyc("R6");
    check("R6", tog_out == 1'b1, "tog after match", tog_out, 1);
    check("R9", irq_out == 1'b1, "irq after match", irq_out, 1);
    check("R5", cnt_lo == 4'd0, "count cleared by match", cnt_lo, 0);
    cyc("R9");
    check("R9", irq_out == 1'b0, "irq one cycle only", irq_out, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule